// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block evaluates a set of Boolean outputs as sums of products over a small vector of input literals. A pool of product terms sits between the inputs and the outputs, and any term may feed any number of outputs. Each term holds a personality that gives every input one of four roles:

- the input is used as it is;
- the input is used inverted;
- the input is ignored;
- the term is forced low.

Each output holds a connection mask that selects which terms feed its OR gate.

Software or a neighbouring controller loads both planes through a synchronous write port and can read every stored word back. A mode input switches the OR plane between two behaviours. In the fully general mode, any output may use any term. In the grouped mode, output j may use only its own fixed block of consecutive terms.

The evaluation path has no registers. Outputs follow the literals and the stored configuration combinationally.

Top module: `prog_sop_array`

## Requirements
- R1: After reset every stored personality entry is 00 and every connection mask is zero, so all outputs are 0 and every readback word is 0.
- R2: A personality entry for input i sits at bits [2i+1:2i] of the term word. The codes are: 2'b10 passes the input true, 2'b01 passes it complemented, 2'b00 makes the term ignore it, and 2'b11 forces the whole term to 0.
- R3: A product term whose entries are all 2'b00 evaluates to 1 for every input pattern.
- R4: An output with no connected product term evaluates to 0.
- R5: A single product term may drive several outputs at once. The four-output reference functions F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A evaluate correctly for every input combination, with A, B and C on inputs 0, 1 and 2.
- R6: With mode_grouped low, bit t of output j's mask connects term t to output j for any t.
- R7: With mode_grouped high, output j sees only terms j*G through j*G+G-1, where G = N_TERM/N_OUT (4 by default). Mask bits outside that block have no effect on the output.
- R8: With mode_grouped high, an OR-plane write leaves the stored mask bits outside the output's block unchanged, and those bits read back as 0. With mode_grouped low, the same bits read back as stored.
- R9: A write with cfg_we high at a rising edge changes the outputs only after that edge. Without cfg_we, the stored configuration never changes.
- R10: With cfg_plane = 0, readback returns the personality word of term cfg_addr. With cfg_plane = 1, it returns the mask of output cfg_addr. Unused high bits and out-of-range addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_grouped | input | 1 | 0: any term to any output; 1: fixed term block per output |
| cfg_we | input | 1 | Write strobe for the configuration |
| cfg_plane | input | 1 | 0 selects the term personality plane, 1 selects the output mask plane |
| cfg_addr | input | AW (4) | Term index or output index |
| cfg_wdata | input | CW (16) | Word to write |
| cfg_rdata | output | CW (16) | Stored word at cfg_plane/cfg_addr, masked in grouped mode |
| lit_in | input | N_IN (4) | Input literals |
| f_out | output | N_OUT (4) | Sum-of-products outputs |

## Verification
The hardest condition to reach from the ports is a mask bit stored outside an output's own block while the array is in grouped mode. Grouped-mode writes can never create such a bit. The stimulus therefore writes an out-of-block mask in the general mode and then switches the mode. It checks that the output ignores the stray bit, writes the same output again in grouped mode, and reads the word back in both modes to confirm that the stray bit survived. Full sweeps over all sixteen input patterns run after every configuration change, covering each literal code and both reference programmings.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        LIT_DC   = 2'b00,
        LIT_NEG  = 2'b01,
        LIT_POS  = 2'b10,
        LIT_KILL = 2'b11
    } lit_code_e;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic lit_pass(input logic [1:0] code, input logic x);
        logic r;
        unique case (lit_code_e'(code))
            LIT_DC:   r = 1'b1;
            LIT_NEG:  r = ~x;
            LIT_POS:  r = x;
            LIT_KILL: r = 1'b0;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sop_group_map.sv
module sop_group_map #(
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16
) (
    output logic [N_OUT*N_TERM-1:0] grp_flat
);
    localparam int G = (N_TERM / N_OUT > 0) ? N_TERM / N_OUT : 1;

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            assign grp_flat[j*N_TERM + t] = ((t / G) == j) ? 1'b1 : 1'b0;
        end
    end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16,
    parameter int CW     = 16,
    parameter int AW     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_grouped,
    input  logic                       cfg_we,
    input  logic                       cfg_plane,
    input  logic [AW-1:0]              cfg_addr,
    input  logic [CW-1:0]              cfg_wdata,
    input  logic [N_OUT*N_TERM-1:0]    grp_flat,
    output logic [CW-1:0]              cfg_rdata,
    output logic [N_TERM*2*N_IN-1:0]   pers_flat,
    output logic [N_OUT*N_TERM-1:0]    mask_flat
);
    localparam int PW = 2 * N_IN;

    logic [PW-1:0]     and_q [N_TERM];
    logic [N_TERM-1:0] or_q  [N_OUT];
    logic [31:0]       a_idx;

    assign a_idx = 32'(cfg_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < N_TERM; t++) and_q[t] <= '0;
            for (int j = 0; j < N_OUT; j++)  or_q[j]  <= '0;
        end else if (cfg_we) begin
            if (cfg_plane == PLANE_AND) begin
                for (int t = 0; t < N_TERM; t++)
                    if (a_idx == 32'(t)) and_q[t] <= cfg_wdata[PW-1:0];
            end else begin
                for (int j = 0; j < N_OUT; j++)
                    if (a_idx == 32'(j)) begin
                        if (mode_grouped)
                            or_q[j] <= (or_q[j] & ~grp_flat[j*N_TERM +: N_TERM])
                                     | (cfg_wdata[N_TERM-1:0] & grp_flat[j*N_TERM +: N_TERM]);
                        else
                            or_q[j] <= cfg_wdata[N_TERM-1:0];
                    end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_plane == PLANE_AND) begin
            for (int t = 0; t < N_TERM; t++)
                if (a_idx == 32'(t)) cfg_rdata[PW-1:0] = and_q[t];
        end else begin
            for (int j = 0; j < N_OUT; j++)
                if (a_idx == 32'(j))
                    cfg_rdata[N_TERM-1:0] = mode_grouped
                        ? (or_q[j] & grp_flat[j*N_TERM +: N_TERM]) : or_q[j];
        end
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_pf
        assign pers_flat[t*PW +: PW] = and_q[t];
    end
    for (genvar j = 0; j < N_OUT; j++) begin : g_mf
        assign mask_flat[j*N_TERM +: N_TERM] = or_q[j];
    end

    // R9: nothing in either plane moves without the write strobe
    a_r9_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(pers_flat) && $stable(mask_flat)));

    // R8: grouped-mode writes leave out-of-block bits untouched
    for (genvar j = 0; j < N_OUT; j++) begin : g_a8
        a_r8_oob_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && mode_grouped && cfg_plane == PLANE_OR && a_idx == 32'(j))
            |=> ((mask_flat[j*N_TERM +: N_TERM] & ~grp_flat[j*N_TERM +: N_TERM])
                 == $past(mask_flat[j*N_TERM +: N_TERM] & ~grp_flat[j*N_TERM +: N_TERM])));
    end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0]          lit_in,
    input  logic [N_TERM*2*N_IN-1:0] pers_flat,
    output logic [N_TERM-1:0]        term_v
);
    localparam int PW = 2 * N_IN;

    logic [N_TERM*N_IN-1:0] ok_flat;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            assign ok_flat[t*N_IN + i] = lit_pass(pers_flat[t*PW + 2*i +: 2], lit_in[i]);
        end
        assign term_v[t] = &ok_flat[t*N_IN +: N_IN];

        logic kill_seen;
        always_comb begin
            kill_seen = 1'b0;
            for (int i = 0; i < N_IN; i++)
                if (pers_flat[t*PW + 2*i +: 2] == 2'b11) kill_seen = 1'b1;
        end

        // R3: an all-ignore term is a constant 1
        a_r3_all_dc_high: assert property (@(posedge clk) disable iff (!rst_n)
            (pers_flat[t*PW +: PW] == '0) |-> term_v[t]);
        // R2: any 2'b11 entry forces the term low
        a_r2_kill_low: assert property (@(posedge clk) disable iff (!rst_n)
            kill_seen |-> !term_v[t]);
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_grouped,
    input  logic [N_TERM-1:0]       term_v,
    input  logic [N_OUT*N_TERM-1:0] mask_flat,
    input  logic [N_OUT*N_TERM-1:0] grp_flat,
    output logic [N_OUT-1:0]        f_out
);
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        logic [N_TERM-1:0] eff;
        assign eff      = mode_grouped ? (mask_flat[j*N_TERM +: N_TERM] & grp_flat[j*N_TERM +: N_TERM])
                                       : mask_flat[j*N_TERM +: N_TERM];
        assign f_out[j] = |(eff & term_v);

        // R4: no connected term means the output is 0
        a_r4_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_flat[j*N_TERM +: N_TERM] == '0) |-> !f_out[j]);
        // R7: in grouped mode only the output's own block can raise it
        a_r7_group_only: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_grouped && ((mask_flat[j*N_TERM +: N_TERM] & grp_flat[j*N_TERM +: N_TERM] & term_v) == '0))
            |-> !f_out[j]);
    end
endmodule

// File: rtl/prog_sop_array.sv
module prog_sop_array
    import sop_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int N_TERM = 16,
    localparam int CW    = max2(2 * N_IN, N_TERM),
    localparam int AW    = (max2(N_TERM, N_OUT) > 1) ? $clog2(max2(N_TERM, N_OUT)) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_grouped,
    input  logic            cfg_we,
    input  logic            cfg_plane,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [CW-1:0]   cfg_wdata,
    output logic [CW-1:0]   cfg_rdata,
    input  logic [N_IN-1:0] lit_in,
    output logic [N_OUT-1:0] f_out
);
    logic [N_OUT*N_TERM-1:0]  grp_flat;
    logic [N_TERM*2*N_IN-1:0] pers_flat;
    logic [N_OUT*N_TERM-1:0]  mask_flat;
    logic [N_TERM-1:0]        term_v;

    sop_group_map #(.N_OUT(N_OUT), .N_TERM(N_TERM)) grp_i (
        .grp_flat (grp_flat)
    );

    sop_cfg_store #(.N_IN(N_IN), .N_OUT(N_OUT), .N_TERM(N_TERM), .CW(CW), .AW(AW)) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_grouped (mode_grouped),
        .cfg_we       (cfg_we),
        .cfg_plane    (cfg_plane),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .grp_flat     (grp_flat),
        .cfg_rdata    (cfg_rdata),
        .pers_flat    (pers_flat),
        .mask_flat    (mask_flat)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) and_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lit_in    (lit_in),
        .pers_flat (pers_flat),
        .term_v    (term_v)
    );

    sop_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) or_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_grouped (mode_grouped),
        .term_v       (term_v),
        .mask_flat    (mask_flat),
        .grp_flat     (grp_flat),
        .f_out        (f_out)
    );

    // R1: the cycle after reset leaves nothing connected
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (f_out == '0));
endmodule

// File: tb/prog_sop_array_tb_top.sv
module prog_sop_array_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_grouped = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_plane = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  lit_in = '0;
    logic [3:0]  f_out;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  m_and [16];
    logic [15:0] m_or  [4];

    always #(CLK_P/2) clk = ~clk;

    prog_sop_array dut_i (
        .clk(clk), .rst_n(rst_n), .mode_grouped(mode_grouped), .cfg_we(cfg_we),
        .cfg_plane(cfg_plane), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lit_in(lit_in), .f_out(f_out)
    );

    function automatic logic [15:0] grp_of(input int j);
        return 16'h000F << (4 * j);
    endfunction

    function automatic logic [3:0] model_f(input logic [3:0] x);
        logic [15:0] tv;
        logic [3:0]  r;
        for (int t = 0; t < 16; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < 4; i++) begin
                case (m_and[t][2*i +: 2])
                    2'b01: if (x[i])  tv[t] = 1'b0;
                    2'b10: if (!x[i]) tv[t] = 1'b0;
                    2'b11: tv[t] = 1'b0;
                    default: ;
                endcase
            end
        end
        for (int j = 0; j < 4; j++)
            r[j] = |(tv & m_or[j] & (mode_grouped ? grp_of(j) : 16'hFFFF));
        return r;
    endfunction

    function automatic logic [7:0] pers(input logic [1:0] c0, input logic [1:0] c1,
                                        input logic [1:0] c2, input logic [1:0] c3);
        return {c3, c2, c1, c0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic plane, input int addr, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = plane; cfg_addr = 4'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!plane) m_and[addr] = d[7:0];
        else if (mode_grouped) m_or[addr] = (m_or[addr] & ~grp_of(addr)) | (d & grp_of(addr));
        else m_or[addr] = d;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic plane, input int addr);
        logic [15:0] e;
        cfg_plane = plane; cfg_addr = 4'(addr);
        #1;
        if (!plane) e = {8'h00, m_and[addr]};
        else e = mode_grouped ? (m_or[addr] & grp_of(addr)) : m_or[addr];
        chk(req, 32'(cfg_rdata), 32'(e));
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < 16; x++) begin
            lit_in = 4'(x);
            #1;
            chk(req, 32'(f_out), 32'(model_f(4'(x))));
        end
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int t = 0; t < 16; t++) m_and[t] = '0;
        for (int j = 0; j < 4; j++) m_or[j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1: reset state
        for (int x = 0; x < 16; x += 5) begin
            lit_in = 4'(x); #1;
            chk("R1 outputs after reset", 32'(f_out), 32'h0);
        end
        rd_chk("R1 readback term 7", 1'b0, 7);
        rd_chk("R1 readback mask 3", 1'b1, 3);

        // R2 / R3: single term on output 0, codes on input 1
        wr(1'b1, 0, 16'h0001);
        for (int x = 0; x < 16; x++) begin
            lit_in = 4'(x); #1;
            chk("R3 all-ignore term", 32'(f_out[0]), 32'h1);
        end
        for (int c = 0; c < 4; c++) begin
            wr(1'b0, 0, 16'(pers(2'b00, 2'(c), 2'b00, 2'b00)));
            sweep("R2 literal code sweep");
        end
        wr(1'b0, 0, 16'(pers(2'b00, 2'b00, 2'b11, 2'b00)));
        lit_in = 4'hF; #1;
        chk("R2 kill code forces term low", 32'(f_out[0]), 32'h0);
        rd_chk("R10 readback personality", 1'b0, 0);
        cfg_plane = 1'b0; cfg_addr = 4'd15; #1;
        chk("R10 readback unwritten term", 32'(cfg_rdata), 32'h0);

        // R4 / R5 / R6: reference functions in general mode
        wr(1'b0, 0, 16'(pers(2'b10, 2'b00, 2'b00, 2'b00)));
        wr(1'b0, 1, 16'(pers(2'b00, 2'b01, 2'b01, 2'b00)));
        wr(1'b0, 2, 16'(pers(2'b10, 2'b00, 2'b01, 2'b00)));
        wr(1'b0, 3, 16'(pers(2'b10, 2'b10, 2'b00, 2'b00)));
        wr(1'b0, 4, 16'(pers(2'b00, 2'b01, 2'b10, 2'b00)));
        for (int x = 0; x < 16; x++) begin
            lit_in = 4'(x); #1;
            chk("R4 unconnected outputs low", 32'(f_out[3:1]), 32'h0);
        end
        wr(1'b1, 0, 16'h0003);
        wr(1'b1, 1, 16'h000C);
        wr(1'b1, 2, 16'h000A);
        wr(1'b1, 3, 16'h0011);
        sweep("R5 reference functions general mode");
        lit_in = 4'b0000; #1;
        chk("R5 shared term B'C' on F0 and F2", 32'(f_out), 32'h5);
        lit_in = 4'b0011; #1;
        chk("R6 A.B on F1 and F2", 32'(f_out), 32'hF);
        rd_chk("R10 readback mask 3", 1'b1, 3);

        // R7: same program in grouped mode loses out-of-block terms
        mode_grouped = 1'b1; #1;
        sweep("R7 grouped mode blocks foreign terms");
        lit_in = 4'b0011; #1;
        chk("R7 only F0 survives", 32'(f_out), 32'h1);

        // R8: out-of-block bit created in general mode
        mode_grouped = 1'b0;
        wr(1'b1, 1, 16'h8001);
        rd_chk("R8 general readback", 1'b1, 1);
        mode_grouped = 1'b1; #1;
        rd_chk("R8 grouped readback hides bits", 1'b1, 1);
        wr(1'b1, 1, 16'hFFF0);
        cfg_plane = 1'b1; cfg_addr = 4'd1; #1;
        chk("R8 grouped write readback", 32'(cfg_rdata), 32'h00F0);
        mode_grouped = 1'b0; #1;
        chk("R8 out-of-block bits kept", 32'(cfg_rdata), 32'h80F1);
        mode_grouped = 1'b1; #1;

        // R7 reference: grouped programming
        wr(1'b0, 5, 16'(pers(2'b10, 2'b10, 2'b00, 2'b00)));
        wr(1'b0, 4, 16'(pers(2'b10, 2'b00, 2'b01, 2'b00)));
        wr(1'b0, 8, 16'(pers(2'b00, 2'b01, 2'b01, 2'b00)));
        wr(1'b0, 9, 16'(pers(2'b10, 2'b10, 2'b00, 2'b00)));
        wr(1'b0, 12, 16'(pers(2'b00, 2'b01, 2'b10, 2'b00)));
        wr(1'b0, 13, 16'(pers(2'b10, 2'b00, 2'b00, 2'b00)));
        wr(1'b1, 1, 16'h0030);
        wr(1'b1, 2, 16'h0300);
        wr(1'b1, 3, 16'h3000);
        sweep("R7 reference functions grouped mode");
        lit_in = 4'b0000; #1;
        chk("R7 grouped reference at 000", 32'(f_out), 32'h5);

        // R9: write takes effect only at the edge
        lit_in = 4'b0111; #1;
        chk("R9 before write", 32'(f_out[0]), 32'h1);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = 1'b0; cfg_addr = 4'd0;
        cfg_wdata = 16'(pers(2'b11, 2'b00, 2'b00, 2'b00));
        #(CLK_P/4);
        chk("R9 no change before edge", 32'(f_out[0]), 32'h1);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        m_and[0] = pers(2'b11, 2'b00, 2'b00, 2'b00);
        chk("R9 change after edge", 32'(f_out[0]), 32'h0);
        repeat (2) @(negedge clk);
        rd_chk("R9 held without strobe", 1'b0, 0);
        sweep("R9 final sweep");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule